// File: doc/BRIEF.md
# Configurable Programmable-Logic Output Cell

This block models a single output cell of a programmable logic device. It takes one sum-of-products bit and passes it to a pin through one storage element. Static configuration bits set that element to one of four kinds: a plain bypass, an edge-triggered data flip-flop, an edge-triggered toggle flip-flop, or a level-sensitive transparent latch. The cell has its own clock term, its own clear term, its own set term and its own output-enable term, so each cell in an array can run on its own timing.

The cell's clock term is a data signal. It is sampled on the system clock `clk`, and its active edge or level is found from that sample. The clear and set terms act at once on the output, and their effect is written into storage on the next `clk` edge. The value after the polarity stage drives the pin, with a separate enable, and the same value always returns to the routing fabric on `fb`. A power-on reset input clears the cell. A test port loads any value into storage.

Top module: `cpld_out_cell`

## Requirements
- R1: With `cfg_mode` = 2'b00 (bypass), `pin_out` equals `sop` XOR `cfg_out_inv` in the same cycle, whatever the clock term does.
- R2: With `cfg_mode` = 2'b01 (data flip-flop), storage takes `sop` on each active edge of the clock term. With `cfg_mode` = 2'b10 (toggle flip-flop), storage inverts on an active edge when `sop` is 1 and holds when `sop` is 0.
- R3: `cfg_out_inv` = 1 inverts the cell value on `pin_out` and `fb` in every mode.
- R4: `cfg_clk_inv` = 0 makes the rising edge of `cell_clk` active (latch open while high). `cfg_clk_inv` = 1 makes the falling edge active (latch open while low).
- R5: While `ar` is high in a storing mode, the cell value is 0 at once. It stays 0 when `ap` is high as well, and storage holds 0 after the next `clk` edge.
- R6: While `ap` is high and `ar` is low in a storing mode, the cell value is 1 at once, and storage holds 1 after the next `clk` edge.
- R7: `pin_oe` follows `oe_term`. `fb` equals `pin_out` whether the driver is enabled or not.
- R8: `por` clears storage. On the first `clk` edge after `por` falls, a clock term that is already at its active level does not count as an edge.
- R9: With `pl_en` high and no clear or set, storage takes `pl_data` on the next `clk` edge. When `ar` or `ap` is high in the same cycle, the clear or set decides the stored value.
- R10: With `cfg_mode` = 2'b11 (latch), the cell value follows `sop` while the clock term is at its open level, and holds the last value once that level ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| por | input | 1 | Power-on reset, active high, synchronous to `clk` |
| cfg_mode | input | 2 | Storage kind: 00 bypass, 01 data FF, 10 toggle FF, 11 latch |
| cfg_out_inv | input | 1 | Output polarity: 1 inverts |
| cfg_clk_inv | input | 1 | Clock or open-level polarity: 1 selects falling edge or low level |
| sop | input | 1 | Sum-of-products data bit |
| cell_clk | input | 1 | Per-cell clock or latch-enable term |
| ar | input | 1 | Per-cell asynchronous clear term |
| ap | input | 1 | Per-cell asynchronous set term |
| oe_term | input | 1 | Per-cell output-enable term |
| pl_en | input | 1 | Test preload strobe |
| pl_data | input | 1 | Test preload value |
| pin_out | output | 1 | Value for the tri-state pin driver |
| pin_oe | output | 1 | Pin driver enable |
| fb | output | 1 | Feedback to the routing fabric |

## Verification
Two pairs of functions can fall in the same cycle: clear and set, and preload with clear. The bench raises `ar` and `ap` together and expects 0 on the pin before the next `clk` edge. It then strobes `pl_en` with `pl_data` = 1 while `ar` is high, and expects storage to read back 0 after all three are released. A separate pass lines up a power-on-reset release with a clock term that is already active, and judges that storage has not loaded `sop`.

// File: rtl/cpld_out_cell.sv
module cpld_out_cell (
  input  logic       clk,
  input  logic       por,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_out_inv,
  input  logic       cfg_clk_inv,
  input  logic       sop,
  input  logic       cell_clk,
  input  logic       ar,
  input  logic       ap,
  input  logic       oe_term,
  input  logic       pl_en,
  input  logic       pl_data,
  output logic       pin_out,
  output logic       pin_oe,
  output logic       fb
);
  localparam logic [1:0] M_BYP = 2'b00;
  localparam logic [1:0] M_DFF = 2'b01;
  localparam logic [1:0] M_TFF = 2'b10;
  localparam logic [1:0] M_LAT = 2'b11;

  logic q_r, prev_act, armed, q_eff, core;

  wire act      = cell_clk ^ cfg_clk_inv;
  wire edge_hit = armed & act & ~prev_act;

  always_ff @(posedge clk) begin
    if (por) begin
      q_r      <= 1'b0;
      armed    <= 1'b0;
      prev_act <= 1'b0;
    end else begin
      armed    <= 1'b1;
      prev_act <= act;
      if (ar)         q_r <= 1'b0;
      else if (ap)    q_r <= 1'b1;
      else if (pl_en) q_r <= pl_data;
      else begin
        case (cfg_mode)
          M_DFF:   if (edge_hit) q_r <= sop;
          M_TFF:   if (edge_hit) q_r <= q_r ^ sop;
          M_LAT:   if (act)      q_r <= sop;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    if (por)                          q_eff = 1'b0;
    else if (ar)                      q_eff = 1'b0;
    else if (ap)                      q_eff = 1'b1;
    else if (cfg_mode == M_LAT && act) q_eff = sop;
    else                              q_eff = q_r;
  end

  assign core    = (cfg_mode == M_BYP) ? sop : q_eff;
  assign pin_out = core ^ cfg_out_inv;
  assign fb      = pin_out;
  assign pin_oe  = oe_term;

  // R5: a clear term leaves zero in storage
  a_r5_clear_stores_zero: assert property (@(posedge clk) disable iff (por)
    ar |=> (q_r == 1'b0));

  // R6: a set term alone leaves one in storage
  a_r6_set_stores_one: assert property (@(posedge clk) disable iff (por)
    (ap && !ar) |=> (q_r == 1'b1));

  // R9: preload with no clear or set stores the preload value
  a_r9_preload_loads: assert property (@(posedge clk) disable iff (por)
    (pl_en && !ar && !ap) |=> (q_r == $past(pl_data)));

  // R2: a toggle edge with sop high flips storage
  a_r2_toggle_flips: assert property (@(posedge clk) disable iff (por)
    (cfg_mode == M_TFF && edge_hit && sop && !ar && !ap && !pl_en) |=> (q_r != $past(q_r)));

  // R8: power-on reset leaves storage cleared and edges disarmed
  a_r8_por_clears: assert property (@(posedge clk)
    por |=> (q_r == 1'b0 && !armed));
endmodule

// File: tb/sim_cpld_out_cell.sv
module sim_cpld_out_cell;
  logic clk = 1'b0;
  logic por = 1'b1;
  logic [1:0] cfg_mode = 2'b00;
  logic cfg_out_inv = 1'b0, cfg_clk_inv = 1'b0;
  logic sop = 1'b0, cell_clk = 1'b0, ar = 1'b0, ap = 1'b0;
  logic oe_term = 1'b0, pl_en = 1'b0, pl_data = 1'b0;
  logic pin_out, pin_oe, fb;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  cpld_out_cell u0 (.clk, .por, .cfg_mode, .cfg_out_inv, .cfg_clk_inv, .sop,
    .cell_clk, .ar, .ap, .oe_term, .pl_en, .pl_data, .pin_out, .pin_oe, .fb);

  // {out_inv, sop, oe, expected pin_out, expected pin_oe} for bypass mode (R1, R3, R7)
  localparam logic [4:0] VEC [8] = '{
    5'b00000, 5'b01010, 5'b10010, 5'b11000,
    5'b00101, 5'b01111, 5'b10111, 5'b11101 };

  task automatic chk(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic por_pulse();
    por = 1'b1; step(); por = 1'b0; step();
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic refq;
    logic [4:0] pat;
    step(); step();
    por = 1'b0; step();
    chk("R8 reset state", pin_out, 1'b0);

    foreach (VEC[i]) begin
      {cfg_out_inv, sop, oe_term} = VEC[i][4:2];
      settle();
      chk("R1 bypass pin", pin_out, VEC[i][1]);
      chk("R7 oe", pin_oe, VEC[i][0]);
      chk("R7 fb tracks pin", fb, VEC[i][1]);
    end
    oe_term = 1'b0;

    pat = 5'b01011;
    for (int m = 0; m < 4; m++) begin
      for (int oi = 0; oi < 2; oi++) begin
        for (int ci = 0; ci < 2; ci++) begin
          cfg_mode = 2'(m); cfg_out_inv = 1'(oi); cfg_clk_inv = 1'(ci);
          sop = 1'b0; cell_clk = 1'(ci);
          por_pulse();
          chk("R8 cleared per config", pin_out, 1'(oi));
          refq = 1'b0;
          for (int k = 0; k < 5; k++) begin
            logic v, exp_a, exp_b;
            v = pat[k];
            sop = v; cell_clk = 1'(ci) ^ 1'b1;
            step();
            case (m)
              0: exp_a = v;
              1: begin refq = v; exp_a = refq; end
              2: begin refq = refq ^ v; exp_a = refq; end
              default: begin refq = v; exp_a = v; end
            endcase
            chk(m == 3 ? "R10 latch open R4" : "R2 active edge R4", pin_out, exp_a ^ 1'(oi));
            sop = ~v; cell_clk = 1'(ci);
            step();
            exp_b = (m == 0) ? ~v : refq;
            chk(m == 3 ? "R10 latch hold R3" : "R2 no edge R3", pin_out, exp_b ^ 1'(oi));
            chk("R3 fb polarity", fb, exp_b ^ 1'(oi));
          end
        end
      end
    end

    cfg_mode = 2'b01; cfg_out_inv = 1'b0; cfg_clk_inv = 1'b0;
    sop = 1'b1; cell_clk = 1'b0;
    por_pulse();
    ar = 1'b1; settle();
    chk("R5 clear immediate", pin_out, 1'b0);
    ap = 1'b1; settle();
    chk("R5 clear beats set", pin_out, 1'b0);
    ar = 1'b0; settle();
    chk("R6 set immediate", pin_out, 1'b1);
    step(); ap = 1'b0; settle();
    chk("R6 set stored", pin_out, 1'b1);
    ar = 1'b1; step(); ar = 1'b0; settle();
    chk("R5 clear stored", pin_out, 1'b0);

    pl_en = 1'b1; pl_data = 1'b1; step(); pl_en = 1'b0; settle();
    chk("R9 preload one", pin_out, 1'b1);
    pl_en = 1'b1; pl_data = 1'b0; step(); pl_en = 1'b0; settle();
    chk("R9 preload zero", pin_out, 1'b0);
    pl_en = 1'b1; pl_data = 1'b1; ar = 1'b1; step();
    pl_en = 1'b0; ar = 1'b0; settle();
    chk("R9 clear beats preload", pin_out, 1'b0);
    pl_en = 1'b1; pl_data = 1'b0; ap = 1'b1; step();
    pl_en = 1'b0; ap = 1'b0; settle();
    chk("R9 set beats preload", pin_out, 1'b1);

    cfg_mode = 2'b01; sop = 1'b1; cell_clk = 1'b1;
    por = 1'b1; step(); por = 1'b0; step(); step();
    chk("R8 first edge ignored", pin_out, 1'b0);

    oe_term = 1'b0; pl_en = 1'b1; pl_data = 1'b1; step(); pl_en = 1'b0; settle();
    chk("R7 fb with driver off", fb, 1'b1);
    chk("R7 oe low", pin_oe, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule